// File: doc/BRIEF.md
# Partitioned Cache Portion Bitmap Store

This block keeps, for every partition identifier, a bitmap that says which portions of a shared cache that partition may fill. Software picks a target partition (and, when several cache instances share one configuration frame, a resource instance) by writing a selector register. It then reads and writes the chosen partition's bitmap as 32-bit words through a register window. Word `n` of the window holds portions `32n` to `32n+31`, with bit `x` of the word standing for portion `32n+x`. A bit set to 1 lets the partition allocate into that portion, and a bit cleared to 0 forbids it.

Two banks are kept, one for the secure security state and one for the non-secure state. Each bank has its own selector and its own storage, and the bus frame input picks which bank an access uses. The cache queries the store through a combinational lookup port. The port takes a security state, a partition, an instance and a portion number. It splits the portion number into a word index (`p >> 5`) and a bit index (`p & 31`) and returns the allocate-permit bit.

Top module: `cpbm_store`

## Requirements
- R1: After reset both selectors read as zero, and every implemented bitmap bit of every partition and instance in both banks is 1. With the default 48-portion width, word 0 reads 0xFFFFFFFF, word 1 reads 0x0000FFFF, and the lookup permits.
- R2: A write to byte offset 0x1000 + 4*n stores the data into word n of the bitmap named by that frame's selector. A later read of that offset returns it, and other partitions keep their own bitmaps.
- R3: The lookup uses word p >> 5 and bit p & 31 of the addressed bitmap for portion p. It returns 1 when that bit is 1 and 0 when it is 0.
- R4: With `bus_secure` = 1 an access uses the secure selector and bitmaps, and with 0 the non-secure ones. A write through one frame never changes what the other frame or the other lookup state reads.
- R5: The selector sits at offset 0x100. It holds the partition in bits [15:0] and the instance in bits [27:24], and every other bit reads as 0. A selector write takes effect at the next clock edge.
- R6: When instance support is enabled, window accesses go to the instance named in bits [27:24] of the selector, and the lookup uses `lk_inst`. Each instance keeps its own bitmaps.
- R7: When instance support is disabled, the instance field and `lk_inst` are ignored. Accesses with any instance value reach the same storage.
- R8: Bits whose portion index is at or beyond the configured width read as 0 and ignore writes. Window words at or beyond ceil(width/32) read as 0 and ignore writes.
- R9: If the selector names a partition or instance out of range, window reads return 0 and window writes change no stored bit.
- R10: The lookup returns 0 when the portion is at or beyond the width, or when the partition or (with instance support) the instance is out of range.
- R11: When the portioning feature is disabled, no bitmap storage exists. The window reads as 0 and writes have no effect, the selectors still work, and the lookup permits every portion below the width.
- R12: Bitmap and selector writes take effect at the clock edge that samples `bus_wr`. In the cycle of a write, the lookup and the read data still show the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_secure | input | 1 | Frame select: 1 secure, 0 non-secure |
| bus_addr | input | 13 | Byte offset within the frame |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| lk_secure | input | 1 | Security state of the lookup |
| lk_part | input | 16 | Partition of the lookup |
| lk_inst | input | 4 | Resource instance of the lookup |
| lk_portion | input | 16 | Cache portion number to test |
| lk_permit | output | 1 | 1 when the partition may allocate into the portion |

## Verification
A bus write to a bitmap word and a lookup of the same partition and portion can fall in the same cycle. The bench provokes this by holding a lookup on portion 0 of one partition while it drives a write that clears that word. In the write cycle it expects the old permit and old read data, and from the following cycle it expects the cleared bit. Banks, instances and out-of-range selectors are judged by sweeping lookups after each write, so that a write landing in the wrong place shows up as a cleared permit.

// File: rtl/cpbm_pkg.sv
package cpbm_pkg;

    localparam int ADDR_W     = 13;
    localparam int WORD_IDX_W = 10;
    localparam int PWORD_W    = 11;

    localparam logic [ADDR_W-1:0] SEL_ADDR    = 13'h100;
    localparam logic [31:0]       SEL_RD_MASK = 32'h0F00_FFFF;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SEL  = 2'd1,
        ACC_WIN  = 2'd2
    } acc_e;

    typedef struct packed {
        logic [3:0]  inst;
        logic [15:0] part;
    } sel_t;

    typedef struct packed {
        acc_e                  kind;
        logic [WORD_IDX_W-1:0] word;
    } acc_t;

    function automatic sel_t sel_from_word(input logic [31:0] w);
        sel_t s;
        s.inst = w[27:24];
        s.part = w[15:0];
        return s;
    endfunction

    function automatic logic [31:0] sel_to_word(input sel_t s);
        return {4'h0, s.inst, 8'h00, s.part};
    endfunction

    // portion p lives in word p >> 5, bit p & 31
    function automatic logic [PWORD_W-1:0] portion_word(input logic [15:0] p);
        return p[15:5];
    endfunction

    function automatic logic [4:0] portion_bit(input logic [15:0] p);
        return p[4:0];
    endfunction

    function automatic acc_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_t r;
        r.kind = ACC_NONE;
        r.word = a[11:2];
        if (a[1:0] == 2'b00) begin
            if (a == SEL_ADDR)
                r.kind = ACC_SEL;
            else if (a[12])
                r.kind = ACC_WIN;
        end
        return r;
    endfunction

endpackage

// File: rtl/cpbm_selector.sv
module cpbm_selector
    import cpbm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output sel_t        sel
);

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (we)
            sel <= sel_from_word(wdata);
    end

endmodule

// File: rtl/cpbm_bank.sv
module cpbm_bank
    import cpbm_pkg::*;
#(
    parameter int NUM_PART = 8,
    parameter int NUM_INST = 2,
    parameter int BM_WIDTH = 48,
    parameter bit HAS_INST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [WORD_IDX_W-1:0] word,
    input  logic [31:0]           wdata,
    input  sel_t                  sel,
    output logic [31:0]           rdata,
    input  logic [15:0]           lk_part,
    input  logic [3:0]            lk_inst,
    output logic [((BM_WIDTH+31)/32)*32-1:0] lk_row,
    output logic                  lk_hit
);

    localparam int NUM_WORDS = (BM_WIDTH + 31) / 32;
    localparam int PAD_W     = NUM_WORDS * 32;
    localparam int INST_N    = HAS_INST ? NUM_INST : 1;
    localparam int PI_W      = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;
    localparam int II_W      = (INST_N > 1) ? $clog2(INST_N) : 1;
    localparam int WI_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic [BM_WIDTH-1:0] mem [INST_N][NUM_PART];

    // window side resolution
    logic            sel_ok, word_ok;
    logic [PI_W-1:0] w_pidx;
    logic [II_W-1:0] w_iidx;
    logic [WI_W-1:0] w_slot;
    logic [PAD_W-1:0] cur_pad, next_pad;
    logic [BM_WIDTH-1:0] next_row;

    always_comb begin
        sel_ok  = (32'(sel.part) < NUM_PART) &&
                  (!HAS_INST || (32'(sel.inst) < NUM_INST));
        word_ok = 32'(word) < NUM_WORDS;
        w_pidx  = sel.part[PI_W-1:0];
        w_iidx  = HAS_INST ? sel.inst[II_W-1:0] : '0;
        w_slot  = word[WI_W-1:0];

        cur_pad = '0;
        cur_pad[BM_WIDTH-1:0] = mem[w_iidx][w_pidx];

        next_pad = cur_pad;
        next_pad[32*w_slot +: 32] = wdata;
        next_row = next_pad[BM_WIDTH-1:0];

        rdata = (sel_ok && word_ok) ? cur_pad[32*w_slot +: 32] : 32'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < INST_N; i++)
                for (int p = 0; p < NUM_PART; p++)
                    mem[i][p] <= '1;
        end else if (we && sel_ok && word_ok) begin
            mem[w_iidx][w_pidx] <= next_row;
        end
    end

    // lookup side resolution
    logic            lk_ok;
    logic [PI_W-1:0] l_pidx;
    logic [II_W-1:0] l_iidx;

    always_comb begin
        lk_ok  = (32'(lk_part) < NUM_PART) &&
                 (!HAS_INST || (32'(lk_inst) < NUM_INST));
        l_pidx = lk_part[PI_W-1:0];
        l_iidx = HAS_INST ? lk_inst[II_W-1:0] : '0;
        lk_row = '0;
        if (lk_ok)
            lk_row[BM_WIDTH-1:0] = mem[l_iidx][l_pidx];
        lk_hit = lk_ok;
    end

endmodule

// File: rtl/cpbm_probe.sv
module cpbm_probe
    import cpbm_pkg::*;
#(
    parameter int BM_WIDTH = 48
) (
    input  logic [((BM_WIDTH+31)/32)*32-1:0] row,
    input  logic                             hit,
    input  logic [15:0]                      portion,
    output logic                             permit
);

    localparam int NUM_WORDS = (BM_WIDTH + 31) / 32;
    localparam int WI_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic               in_range;
    logic [PWORD_W-1:0] widx;
    logic [4:0]         bidx;
    logic [WI_W-1:0]    slot;
    logic [31:0]        word_bits;

    always_comb begin
        in_range  = 32'(portion) < BM_WIDTH;
        widx      = portion_word(portion);
        bidx      = portion_bit(portion);
        slot      = widx[WI_W-1:0];
        word_bits = row[32*slot +: 32];
        permit    = hit && in_range && word_bits[bidx];
    end

endmodule

// File: rtl/cpbm_store.sv
module cpbm_store
    import cpbm_pkg::*;
#(
    parameter int NUM_PART    = 8,
    parameter int NUM_INST    = 2,
    parameter int BM_WIDTH    = 48,
    parameter bit HAS_INST    = 1'b1,
    parameter bit HAS_PORTION = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_secure,
    input  logic [12:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        lk_secure,
    input  logic [15:0] lk_part,
    input  logic [3:0]  lk_inst,
    input  logic [15:0] lk_portion,
    output logic        lk_permit
);

    localparam int NUM_WORDS = (BM_WIDTH + 31) / 32;
    localparam int PAD_W     = NUM_WORDS * 32;
    localparam int NUM_BANKS = 2;

    acc_t acc;
    assign acc = decode_addr(bus_addr);

    sel_t             sel_q    [NUM_BANKS];
    logic [31:0]      bank_rd  [NUM_BANKS];
    logic [PAD_W-1:0] bank_row [NUM_BANKS];
    logic             bank_hit [NUM_BANKS];

    // bank 1 is secure, bank 0 non-secure
    for (genvar s = 0; s < NUM_BANKS; s++) begin : g_bank
        logic frame_hit;
        assign frame_hit = (bus_secure == 1'(s));

        cpbm_selector u_sel (
            .clk   (clk),
            .rst   (rst),
            .we    (bus_wr && frame_hit && (acc.kind == ACC_SEL)),
            .wdata (bus_wdata),
            .sel   (sel_q[s])
        );

        if (HAS_PORTION) begin : g_store
            cpbm_bank #(
                .NUM_PART (NUM_PART),
                .NUM_INST (NUM_INST),
                .BM_WIDTH (BM_WIDTH),
                .HAS_INST (HAS_INST)
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .we      (bus_wr && frame_hit && (acc.kind == ACC_WIN)),
                .word    (acc.word),
                .wdata   (bus_wdata),
                .sel     (sel_q[s]),
                .rdata   (bank_rd[s]),
                .lk_part (lk_part),
                .lk_inst (lk_inst),
                .lk_row  (bank_row[s]),
                .lk_hit  (bank_hit[s])
            );
        end else begin : g_absent
            assign bank_rd[s]  = '0;
            assign bank_row[s] = '0;
            assign bank_hit[s] = 1'b0;
        end
    end

    always_comb begin
        unique case (acc.kind)
            ACC_SEL: bus_rdata = sel_to_word(sel_q[bus_secure]);
            ACC_WIN: bus_rdata = bank_rd[bus_secure];
            default: bus_rdata = 32'h0;
        endcase
    end

    if (HAS_PORTION) begin : g_probe
        cpbm_probe #(
            .BM_WIDTH (BM_WIDTH)
        ) u_probe (
            .row     (bank_row[lk_secure]),
            .hit     (bank_hit[lk_secure]),
            .portion (lk_portion),
            .permit  (lk_permit)
        );
    end else begin : g_open
        assign lk_permit = 32'(lk_portion) < BM_WIDTH;
    end

endmodule

// File: rtl/cpbm_store_chk.sv
module cpbm_store_chk #(
    parameter int NUM_PART    = 8,
    parameter int NUM_INST    = 2,
    parameter int BM_WIDTH    = 48,
    parameter bit HAS_INST    = 1'b1,
    parameter bit HAS_PORTION = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_secure,
    input logic [12:0] bus_addr,
    input logic        bus_wr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        lk_secure,
    input logic [15:0] lk_part,
    input logic [3:0]  lk_inst,
    input logic [15:0] lk_portion,
    input logic        lk_permit
);

    localparam int NUM_WORDS = (BM_WIDTH + 31) / 32;

    function automatic logic [31:0] word_mask(input logic [12:0] a);
        logic [31:0] m;
        m = '0;
        for (int b = 0; b < 32; b++)
            if ((32'(a[11:2]) * 32 + b) < BM_WIDTH)
                m[b] = 1'b1;
        return m;
    endfunction

    function automatic logic is_win(input logic [12:0] a);
        return a[12] && (a[1:0] == 2'b00);
    endfunction

    p_beyond_width_r10: assert property (@(posedge clk) disable iff (rst)
        (32'(lk_portion) >= BM_WIDTH) |-> !lk_permit);

    p_part_range_r10: assert property (@(posedge clk) disable iff (rst)
        (HAS_PORTION && (32'(lk_part) >= NUM_PART)) |-> !lk_permit);

    p_sel_reset_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && (bus_addr == 13'h100)) |-> (bus_rdata == 32'h0));

    p_sel_readback_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_wr) && ($past(bus_addr) == 13'h100) &&
         (bus_addr == 13'h100) && (bus_secure == $past(bus_secure)))
        |-> (bus_rdata == ($past(bus_wdata) & 32'h0F00_FFFF)));

    p_word_pad_r8: assert property (@(posedge clk) disable iff (rst)
        is_win(bus_addr) |-> ((bus_rdata & ~word_mask(bus_addr)) == 32'h0));

    p_word_write_r2: assert property (@(posedge clk) disable iff (rst)
        (HAS_PORTION && !$past(rst) && $past(bus_wr) && is_win($past(bus_addr)) &&
         (bus_addr == $past(bus_addr)) && (bus_secure == $past(bus_secure)))
        |-> ((bus_rdata == ($past(bus_wdata) & word_mask(bus_addr))) ||
             (bus_rdata == 32'h0)));

    p_absent_window_r11: assert property (@(posedge clk) disable iff (rst)
        (!HAS_PORTION && bus_addr[12]) |-> (bus_rdata == 32'h0));

endmodule

bind cpbm_store cpbm_store_chk #(
    .NUM_PART    (NUM_PART),
    .NUM_INST    (NUM_INST),
    .BM_WIDTH    (BM_WIDTH),
    .HAS_INST    (HAS_INST),
    .HAS_PORTION (HAS_PORTION)
) u_chk (.*);

// File: tb/cpbm_store_test.sv
module cpbm_store_test;

    localparam logic [12:0] A_SEL = 13'h100;
    localparam logic [12:0] A_W0  = 13'h1000;
    localparam logic [12:0] A_W1  = 13'h1004;
    localparam logic [12:0] A_W2  = 13'h1008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_secure = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        lk_secure = 1'b0;
    logic [15:0] lk_part = '0;
    logic [3:0]  lk_inst = '0;
    logic [15:0] lk_portion = '0;

    logic [31:0] rd_main, rd_nr, rd_nf;
    logic        pm_main, pm_nr, pm_nf;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpbm_store uut (
        .clk(clk), .rst(rst), .bus_secure(bus_secure), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd_main),
        .lk_secure(lk_secure), .lk_part(lk_part), .lk_inst(lk_inst),
        .lk_portion(lk_portion), .lk_permit(pm_main));

    cpbm_store #(.HAS_INST(1'b0)) uut_nr (
        .clk(clk), .rst(rst), .bus_secure(bus_secure), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd_nr),
        .lk_secure(lk_secure), .lk_part(lk_part), .lk_inst(lk_inst),
        .lk_portion(lk_portion), .lk_permit(pm_nr));

    cpbm_store #(.HAS_PORTION(1'b0)) uut_nf (
        .clk(clk), .rst(rst), .bus_secure(bus_secure), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rd_nf),
        .lk_secure(lk_secure), .lk_part(lk_part), .lk_inst(lk_inst),
        .lk_portion(lk_portion), .lk_permit(pm_nf));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sec, input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_secure = sec; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic sec, input logic [12:0] a);
        @(negedge clk);
        bus_secure = sec; bus_addr = a; bus_wr = 1'b0;
        #1;
    endtask

    task automatic lk(input logic sec, input logic [15:0] part,
                      input logic [3:0] inst, input logic [15:0] portion);
        @(negedge clk);
        lk_secure = sec; lk_part = part; lk_inst = inst; lk_portion = portion;
        #1;
    endtask

    task automatic t_reset;
        rd(1'b0, A_SEL); chk("R1 ns selector", rd_main, 32'h0);
        rd(1'b1, A_SEL); chk("R1 s selector", rd_main, 32'h0);
        rd(1'b0, A_W0);  chk("R1 word0", rd_main, 32'hFFFF_FFFF);
        rd(1'b1, A_W1);  chk("R1 word1", rd_main, 32'h0000_FFFF);
        lk(1'b1, 16'd3, 4'd1, 16'd40); chk("R1 lookup", 32'(pm_main), 32'd1);
    endtask

    task automatic t_word_rw;
        wr(1'b0, A_SEL, 32'h0000_0002);
        wr(1'b0, A_W0, 32'hA5A5_0F0F);
        wr(1'b0, A_W1, 32'h1234_5678);
        rd(1'b0, A_W0); chk("R2 word0", rd_main, 32'hA5A5_0F0F);
        rd(1'b0, A_W1); chk("R2 word1", rd_main, 32'h0000_5678);
        wr(1'b0, A_SEL, 32'h0000_0003);
        rd(1'b0, A_W0); chk("R2 other partition", rd_main, 32'hFFFF_FFFF);
    endtask

    task automatic t_lookup;
        lk(1'b0, 16'd2, 4'd0, 16'd0);  chk("R3 portion 0", 32'(pm_main), 32'd1);
        lk(1'b0, 16'd2, 4'd0, 16'd4);  chk("R3 portion 4", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd2, 4'd0, 16'd31); chk("R3 portion 31", 32'(pm_main), 32'd1);
        lk(1'b0, 16'd2, 4'd0, 16'd32); chk("R3 portion 32", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd2, 4'd0, 16'd35); chk("R3 portion 35", 32'(pm_main), 32'd1);
    endtask

    task automatic t_banks;
        wr(1'b1, A_SEL, 32'h0000_0002);
        rd(1'b1, A_W0); chk("R4 secure untouched", rd_main, 32'hFFFF_FFFF);
        wr(1'b1, A_W0, 32'h0);
        rd(1'b1, A_W0); chk("R4 secure written", rd_main, 32'h0);
        wr(1'b0, A_SEL, 32'h0000_0002);
        rd(1'b0, A_W0); chk("R4 ns kept", rd_main, 32'hA5A5_0F0F);
        lk(1'b1, 16'd2, 4'd0, 16'd0); chk("R4 secure lookup", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd2, 4'd0, 16'd0); chk("R4 ns lookup", 32'(pm_main), 32'd1);
    endtask

    task automatic t_selector;
        wr(1'b0, A_SEL, 32'hFFFF_FFFF);
        rd(1'b0, A_SEL); chk("R5 selector fields", rd_main, 32'h0F00_FFFF);
        rd(1'b1, A_SEL); chk("R5 other selector", rd_main, 32'h0000_0002);
        wr(1'b0, A_SEL, 32'h0000_0002);
    endtask

    task automatic t_instance;
        wr(1'b0, A_SEL, 32'h0100_0002);
        rd(1'b0, A_W0); chk("R6 instance 1 fresh", rd_main, 32'hFFFF_FFFF);
        wr(1'b0, A_W0, 32'h0000_0001);
        lk(1'b0, 16'd2, 4'd1, 16'd0); chk("R6 inst1 portion 0", 32'(pm_main), 32'd1);
        lk(1'b0, 16'd2, 4'd1, 16'd1); chk("R6 inst1 portion 1", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd2, 4'd0, 16'd1); chk("R6 inst0 portion 1", 32'(pm_main), 32'd1);
    endtask

    task automatic t_no_inst;
        wr(1'b0, A_SEL, 32'h0000_0002);
        rd(1'b0, A_W0);
        chk("R7 shared storage", rd_nr, 32'h0000_0001);
        chk("R6 separate storage", rd_main, 32'hA5A5_0F0F);
        lk(1'b0, 16'd2, 4'd1, 16'd1); chk("R7 lookup ignores inst", 32'(pm_nr), 32'd0);
        lk(1'b0, 16'd2, 4'd3, 16'd0); chk("R7 lookup inst 3", 32'(pm_nr), 32'd1);
    endtask

    task automatic t_width;
        wr(1'b0, A_W1, 32'hFFFF_0000);
        rd(1'b0, A_W1); chk("R8 upper bits", rd_main, 32'h0);
        lk(1'b0, 16'd2, 4'd0, 16'd47); chk("R8 portion 47", 32'(pm_main), 32'd0);
        wr(1'b0, A_W2, 32'hFFFF_FFFF);
        rd(1'b0, A_W2); chk("R8 word beyond", rd_main, 32'h0);
        rd(1'b0, A_W0); chk("R8 word0 kept", rd_main, 32'hA5A5_0F0F);
    endtask

    task automatic t_sel_range;
        wr(1'b0, A_SEL, 32'h0000_0008);
        rd(1'b0, A_W0); chk("R9 partition out of range read", rd_main, 32'h0);
        wr(1'b0, A_W0, 32'h0);
        wr(1'b0, A_SEL, 32'h0200_0001);
        rd(1'b0, A_W0); chk("R9 instance out of range read", rd_main, 32'h0);
        wr(1'b0, A_W0, 32'h0);
        for (int p = 0; p < 8; p++)
            for (int i = 0; i < 2; i++) begin
                lk(1'b0, 16'(p), 4'(i), 16'd0);
                chk($sformatf("R9 no stray write p%0d i%0d", p, i), 32'(pm_main), 32'd1);
            end
    endtask

    task automatic t_lookup_range;
        lk(1'b0, 16'd8, 4'd0, 16'd0);      chk("R10 partition 8", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd0, 4'd0, 16'd48);     chk("R10 portion 48", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd0, 4'd0, 16'hFFFF);   chk("R10 portion max", 32'(pm_main), 32'd0);
        lk(1'b0, 16'd0, 4'd2, 16'd0);      chk("R10 instance 2", 32'(pm_main), 32'd0);
    endtask

    task automatic t_no_feature;
        wr(1'b0, A_SEL, 32'h0000_0005);
        rd(1'b0, A_SEL); chk("R11 selector works", rd_nf, 32'h0000_0005);
        wr(1'b0, A_W0, 32'h0000_0000);
        rd(1'b0, A_W0); chk("R11 window reads zero", rd_nf, 32'h0);
        lk(1'b0, 16'd5, 4'd0, 16'd5);  chk("R11 permit in range", 32'(pm_nf), 32'd1);
        lk(1'b0, 16'd5, 4'd0, 16'd48); chk("R11 deny beyond", 32'(pm_nf), 32'd0);
    endtask

    task automatic t_same_cycle;
        wr(1'b0, A_SEL, 32'h0000_0004);
        lk(1'b0, 16'd4, 4'd0, 16'd0);
        @(negedge clk);
        bus_secure = 1'b0; bus_addr = A_W0; bus_wdata = 32'h0; bus_wr = 1'b1;
        #1;
        chk("R12 old permit in write cycle", 32'(pm_main), 32'd1);
        chk("R12 old data in write cycle", rd_main, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        chk("R12 new permit after edge", 32'(pm_main), 32'd0);
        chk("R12 new data after edge", rd_main, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_rw();
        t_lookup();
        t_banks();
        t_selector();
        t_instance();
        t_no_inst();
        t_width();
        t_sel_range();
        t_lookup_range();
        t_no_feature();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            runs++;
            fails++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

endmodule